// File: doc/BRIEF.md
# Hardware Task Switch Controller

This block carries out a complete processor context switch without software help. When a far jump or far call presents a selector, the block looks the selector up in the global descriptor table. If the entry found there is a task-state descriptor, the block writes the live register context into the state area of the task that is running. It then reads the incoming context from the state area the descriptor names and makes that task current by loading its base into the task register.

The block faults when the selector asks for the local table or points past the table limit. It hands the transfer back when the descriptor has any other type, because ordinary far transfers are handled elsewhere. The caller supplies only the selector without its requested-privilege bits; the offset of the jump or call plays no part and is not an input. Memory is reached through one 32-bit word port with a valid/ready handshake. The architectural register file is seen as two flat buses, one carrying the live context and one carrying the incoming context, with a write strobe for the latter.

Top module: `task_switch_ctrl`

## Requirements
- R1: After reset the task register holds the parameter `RESET_TR` (default 0x200). `busy`, `mem_valid`, `done`, `fault`, `other_xfer` and `ctx_we` are all low.
- R2: The selector field `sw_sel[15:3]` is the index and `sw_sel[2]` is the table indicator, where 1 means the local table. The descriptor is read as two words, first at `gdt_base + index*8` and then at that address plus 4. Word 0 holds the base of the new state area. Bits [11:8] of word 1 hold the type. Only type 0x9 counts as a task-state type by default; type 0xB is also accepted when `ACCEPT_BUSY` is 1.
- R3: A selector with the table indicator set pulses `fault` and makes no memory access. The task register stays unchanged and `ctx_we` never rises.
- R4: A selector with `index*8+7 > gdt_limit` faults in the same way as in R3. An index whose last byte equals the limit is accepted.
- R5: A descriptor of any other type pulses `other_xfer` one cycle after the second descriptor word is accepted. Nothing is written to memory, the task register is unchanged and `ctx_we` never rises.
- R6: Each context slot is stored at `old_base + 4*slot`, in ascending slot order, and every store completes before the first context read. Slots 0–7 are the general registers, slot 8 is EIP (offset 0x20), slot 9 is EFLAGS and slots 10–15 are the segment selectors.
- R7: The incoming context is read from `new_base + 4*slot` in ascending order. In the cycle that `done` is high, `ctx_we` is high and each slot of `ctx_out` equals the word read from that slot.
- R8: The task register takes the new base on the clock edge that ends the `done` cycle, and it never changes at any other time. `ctx_we` is high for exactly one cycle per switch.
- R9: Only one outcome is signalled per request, and outcomes arrive as one-cycle pulses: `done`, `fault` or `other_xfer`.
- R10: Once `mem_valid` is high it stays high until `mem_ready` is seen, with `mem_addr`, `mem_we` and `mem_wdata` held steady. Any number of wait cycles is tolerated.
- R11: `sw_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | One-cycle request to transfer through a selector |
| sw_sel | input | 14 | Selector bits [15:2]: index and table indicator |
| gdt_base | input | 32 | Base address of the global descriptor table |
| gdt_limit | input | 16 | Last valid byte offset of the global table |
| ctx_in | input | 512 | Live context, slot k at bits [32k+31:32k] |
| ctx_out | output | 512 | Incoming context, same slot layout |
| ctx_we | output | 1 | Write strobe for the register file |
| task_base | output | 32 | Task register: base of the current state area |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Switch completed pulse |
| fault | output | 1 | Selector rejected pulse |
| other_xfer | output | 1 | Descriptor is not task-state pulse |
| mem_valid | input-side request | 1 | see below |

| Port | Direction | Width | Description |
|---|---|---|---|
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |

## Verification
The bench goes after a selector whose last descriptor byte sits exactly on the table limit, and one index past it. A design with an off-by-one limit test would either fault on the legal entry or fetch from beyond the table. It also sends a selector for the local table and a descriptor with a busy or plain segment type. A design that checked these too late would issue memory traffic, while one that updated state early would move the task register or strobe the register file without finishing a switch. Memory wait states, chained switches and a request raised mid-switch show whether the request is dropped while a switch runs, whether stores precede loads, and whether the second switch saves into the area the first one made current.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CHECK,
      ST_SAVE,
      ST_LOAD,
      ST_COMMIT,
      ST_FAULT
   } tsc_state_e;

   localparam logic [3:0] DTYPE_TASK_FREE = 4'h9;
   localparam logic [3:0] DTYPE_TASK_BUSY = 4'hB;
   localparam int         DTYPE_LSB       = 8;
endpackage

// File: rtl/tsc_sel_decode.sv
module tsc_sel_decode #(
   parameter int AW   = 32,
   parameter int LIMW = 16
) (
   input  logic [15:2]   sel,
   input  logic [AW-1:0] table_base,
   input  logic [LIMW-1:0] table_limit,
   output logic          local_tbl,
   output logic          in_limit,
   output logic [AW-1:0] desc_addr
);
   logic [31:0] last_byte;
   logic [31:0] limit_ext;

   always_comb begin
      last_byte = 32'({sel[15:3], 3'b111});
      limit_ext = 32'(table_limit);
      local_tbl = sel[2];
      in_limit  = (last_byte <= limit_ext);
      desc_addr = table_base + AW'({sel[15:3], 3'b000});
   end
endmodule

// File: rtl/tsc_type_match.sv
module tsc_type_match import tsc_pkg::*; #(
   parameter bit ACCEPT_BUSY = 1'b0
) (
   input  logic [3:0] dtype,
   output logic       is_task
);
   generate
      if (ACCEPT_BUSY) begin : g_free_or_busy
         assign is_task = (dtype == DTYPE_TASK_FREE) || (dtype == DTYPE_TASK_BUSY);
      end else begin : g_free_only
         assign is_task = (dtype == DTYPE_TASK_FREE);
      end
   endgenerate
endmodule

// File: rtl/tsc_ctx_buffer.sv
module tsc_ctx_buffer #(
   parameter int NSLOT = 16,
   parameter int W     = 32,
   parameter int IW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [W-1:0]     wr_data,
   output logic [NSLOT*W-1:0] flat_out
);
   generate
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
         logic [W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (wr_en && (wr_idx == IW'(k))) begin
               word_q <= wr_data;
            end
         end
         assign flat_out[k*W +: W] = word_q;
      end
   endgenerate
endmodule

// File: rtl/tsc_sequencer.sv
module tsc_sequencer import tsc_pkg::*; #(
   parameter int            AW       = 32,
   parameter int            W        = 32,
   parameter int            NSLOT    = 16,
   parameter int            IW       = 4,
   parameter logic [AW-1:0] RESET_TR = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               sel_local,
   input  logic               sel_in_limit,
   input  logic [AW-1:0]      sel_desc_addr,
   input  logic               is_task,
   output logic [3:0]         desc_type,
   input  logic [NSLOT*W-1:0] ctx_in,
   output logic               buf_we,
   output logic [IW-1:0]      buf_idx,
   output logic [W-1:0]       buf_data,
   output logic [AW-1:0]      task_base,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic               other_xfer,
   output logic               ctx_we,
   output logic               mem_valid,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [W-1:0]       mem_wdata,
   input  logic               mem_ready,
   input  logic [W-1:0]       mem_rdata
);
   localparam logic [IW-1:0] LAST_SLOT = IW'(NSLOT - 1);

   tsc_state_e    state;
   logic [IW-1:0] cnt;
   logic [AW-1:0] desc_q;
   logic [AW-1:0] nbase_q;
   logic [3:0]    type_q;
   logic [AW-1:0] tr_q;
   logic          xfer;
   logic [AW-1:0] word_off;

   always_comb begin
      word_off  = AW'({cnt, 2'b00});
      mem_valid = (state == ST_FETCH) || (state == ST_SAVE) || (state == ST_LOAD);
      mem_we    = (state == ST_SAVE);
      xfer      = mem_valid && mem_ready;
      unique case (state)
         ST_FETCH: mem_addr = desc_q + word_off;
         ST_SAVE:  mem_addr = tr_q + word_off;
         ST_LOAD:  mem_addr = nbase_q + word_off;
         default:  mem_addr = '0;
      endcase
      mem_wdata = '0;
      if (state == ST_SAVE) begin
         for (int k = 0; k < NSLOT; k++) begin
            if (cnt == IW'(k)) mem_wdata = ctx_in[k*W +: W];
         end
      end
      buf_we     = (state == ST_LOAD) && xfer;
      buf_idx    = cnt;
      buf_data   = mem_rdata;
      busy       = (state != ST_IDLE);
      done       = (state == ST_COMMIT);
      ctx_we     = (state == ST_COMMIT);
      fault      = (state == ST_FAULT);
      other_xfer = (state == ST_CHECK) && !is_task;
      task_base  = tr_q;
      desc_type  = type_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         desc_q  <= '0;
         nbase_q <= '0;
         type_q  <= '0;
         tr_q    <= RESET_TR;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  desc_q <= sel_desc_addr;
                  cnt    <= '0;
                  state  <= (sel_local || !sel_in_limit) ? ST_FAULT : ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (xfer) begin
                  if (cnt == '0) begin
                     nbase_q <= mem_rdata[AW-1:0];
                     cnt     <= IW'(1);
                  end else begin
                     type_q <= mem_rdata[DTYPE_LSB +: 4];
                     cnt    <= '0;
                     state  <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               cnt   <= '0;
               state <= is_task ? ST_SAVE : ST_IDLE;
            end
            ST_SAVE: begin
               if (xfer) begin
                  if (cnt == LAST_SLOT) begin
                     cnt   <= '0;
                     state <= ST_LOAD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               if (xfer) begin
                  if (cnt == LAST_SLOT) begin
                     cnt   <= '0;
                     state <= ST_COMMIT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_COMMIT: begin
               tr_q  <= nbase_q;
               state <= ST_IDLE;
            end
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // Checking aid: stores accepted since the request left idle.
   logic [IW:0] wr_seen;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_seen <= '0;
      end else if (state == ST_IDLE) begin
         wr_seen <= '0;
      end else if (xfer && mem_we) begin
         wr_seen <= wr_seen + 1'b1;
      end
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

   assert_tr_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (task_base != $past(task_base)) |-> $past(done));

   assert_fault_keeps_tr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (task_base == $past(task_base)));

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault, other_xfer}));

   assert_save_before_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_we && (state == ST_LOAD)) |-> (wr_seen == (IW+1)'(NSLOT)));

   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (state != ST_COMMIT) && (state != ST_FAULT) && (state != ST_CHECK)) |=> busy);
endmodule

// File: rtl/task_switch_ctrl.sv
module task_switch_ctrl import tsc_pkg::*; #(
   parameter int            AW          = 32,
   parameter int            W           = 32,
   parameter int            LIMW        = 16,
   parameter int            NGPR        = 8,
   parameter int            NSEG        = 6,
   parameter bit            ACCEPT_BUSY = 1'b0,
   parameter logic [AW-1:0] RESET_TR    = AW'(32'h200),
   localparam int           NSLOT       = NGPR + 2 + NSEG,
   localparam int           IW          = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_start,
   input  logic [15:2]        sw_sel,
   input  logic [AW-1:0]      gdt_base,
   input  logic [LIMW-1:0]    gdt_limit,
   input  logic [NSLOT*W-1:0] ctx_in,
   output logic [NSLOT*W-1:0] ctx_out,
   output logic               ctx_we,
   output logic [AW-1:0]      task_base,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic               other_xfer,
   output logic               mem_valid,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [W-1:0]       mem_wdata,
   input  logic               mem_ready,
   input  logic [W-1:0]       mem_rdata
);
   generate
      if (W != 32) begin : g_bad_w
         $error("task_switch_ctrl: word width must be 32");
      end
      if (AW > W) begin : g_bad_aw
         $error("task_switch_ctrl: address width exceeds word width");
      end
      if (LIMW > 32 || LIMW < 3) begin : g_bad_lim
         $error("task_switch_ctrl: limit width out of range");
      end
      if (NGPR < 1 || NSEG < 1) begin : g_bad_slots
         $error("task_switch_ctrl: register counts must be positive");
      end
   endgenerate

   logic          sel_local;
   logic          sel_in_limit;
   logic [AW-1:0] sel_desc_addr;
   logic [3:0]    desc_type;
   logic          is_task;
   logic          buf_we;
   logic [IW-1:0] buf_idx;
   logic [W-1:0]  buf_data;

   tsc_sel_decode #(.AW(AW), .LIMW(LIMW)) u_decode (
      .sel         (sw_sel),
      .table_base  (gdt_base),
      .table_limit (gdt_limit),
      .local_tbl   (sel_local),
      .in_limit    (sel_in_limit),
      .desc_addr   (sel_desc_addr)
   );

   tsc_type_match #(.ACCEPT_BUSY(ACCEPT_BUSY)) u_type (
      .dtype   (desc_type),
      .is_task (is_task)
   );

   tsc_ctx_buffer #(.NSLOT(NSLOT), .W(W), .IW(IW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (buf_we),
      .wr_idx   (buf_idx),
      .wr_data  (buf_data),
      .flat_out (ctx_out)
   );

   tsc_sequencer #(
      .AW(AW), .W(W), .NSLOT(NSLOT), .IW(IW), .RESET_TR(RESET_TR)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (sw_start),
      .sel_local     (sel_local),
      .sel_in_limit  (sel_in_limit),
      .sel_desc_addr (sel_desc_addr),
      .is_task       (is_task),
      .desc_type     (desc_type),
      .ctx_in        (ctx_in),
      .buf_we        (buf_we),
      .buf_idx       (buf_idx),
      .buf_data      (buf_data),
      .task_base     (task_base),
      .busy          (busy),
      .done          (done),
      .fault         (fault),
      .other_xfer    (other_xfer),
      .ctx_we        (ctx_we),
      .mem_valid     (mem_valid),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_ready     (mem_ready),
      .mem_rdata     (mem_rdata)
   );

   assert_local_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start && !busy && sw_sel[2]) |=> (fault && !mem_valid));

   assert_we_only_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |-> (done && !fault && !other_xfer));
endmodule

// File: tb/tb_task_switch_ctrl.sv
module tb_task_switch_ctrl;
   localparam int NSLOT = 16;
   localparam logic [31:0] GDT = 32'h100;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sw_start = 1'b0;
   logic [15:2]        sw_sel = '0;
   logic [31:0]        gdt_base = GDT;
   logic [15:0]        gdt_limit = 16'h3F;
   logic [NSLOT*32-1:0] ctx_in = '0;
   logic [NSLOT*32-1:0] ctx_out;
   logic               ctx_we;
   logic [31:0]        task_base;
   logic               busy, done, fault, other_xfer;
   logic               mem_valid, mem_we;
   logic [31:0]        mem_addr, mem_wdata;
   logic               mem_ready = 1'b0;
   logic [31:0]        mem_rdata = '0;

   always #5 clk = ~clk;

   task_switch_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_sel(sw_sel),
      .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ctx_in(ctx_in),
      .ctx_out(ctx_out), .ctx_we(ctx_we), .task_base(task_base),
      .busy(busy), .done(done), .fault(fault), .other_xfer(other_xfer),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [0:1023];
   logic [31:0] log_addr [0:63];
   logic        log_we [0:63];
   int log_n = 0;
   int wait_n = 0;
   int wcnt = 0;
   int hold_bad = 0;
   int we_count = 0;
   int tr_bad = 0;
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   logic        last_done = 1'b0;
   logic [31:0] last_tr = 32'h200;
   int seed = 1;

   // Memory model and port monitors, all at the falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend && !(mem_valid && mem_addr == pend_addr)) hold_bad++;
         if (ctx_we) we_count++;
         if (task_base != last_tr && !last_done) tr_bad++;
      end
      last_done = done;
      last_tr   = task_base;
      if (!rst_n) begin
         mem_ready = 1'b0;
         wcnt = 0;
         pend = 1'b0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         wcnt = 0;
         pend = 1'b0;
      end else if (mem_valid) begin
         if (wcnt >= wait_n) begin
            mem_ready = 1'b1;
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[11:2]];
            if (log_n < 64) begin
               log_addr[log_n] = mem_addr;
               log_we[log_n]   = mem_we;
            end
            log_n++;
            pend = 1'b0;
         end else begin
            wcnt++;
            pend = 1'b1;
            pend_addr = mem_addr;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", req, what, got, exp);
      end
   endtask

   task automatic set_desc(input int idx, input logic [31:0] base, input logic [3:0] dtype);
      mem[(GDT >> 2) + 2*idx]     = base;
      mem[(GDT >> 2) + 2*idx + 1] = 32'(dtype) << 8;
   endtask

   task automatic pulse_start(input int idx, input bit ti);
      sw_sel   = {13'(idx), ti};
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
   endtask

   task automatic wait_outcome(output logic d, output logic f, output logic o);
      d = 0; f = 0; o = 0;
      for (int i = 0; i < 3000; i++) begin
         if (done || fault || other_xfer) begin
            d = done; f = fault; o = other_xfer;
            return;
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1", "task_base", task_base, 32'h200);
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "mem_valid", 32'(mem_valid), 0);
      chk("R1", "outcomes", 32'({done, fault, other_xfer, ctx_we}), 0);
   endtask

   task automatic t_switch(input int idx, input logic [31:0] nbase, input int wt, input bit poke);
      logic [31:0] old;
      logic [31:0] slot [0:NSLOT-1];
      logic d, f, o;
      int we0, hb0;
      old = task_base;
      seed++;
      for (int k = 0; k < NSLOT; k++) begin
         ctx_in[k*32 +: 32] = {16'(seed) ^ 16'hC0DE, 16'(k)};
         slot[k] = 32'h5A00_0000 ^ (nbase << 8) ^ 32'(k);
         mem[(nbase >> 2) + k] = slot[k];
      end
      wait_n = wt; log_n = 0; we0 = we_count; hb0 = hold_bad;
      pulse_start(idx, 1'b0);
      if (poke) begin
         repeat (4) @(negedge clk);
         pulse_start(1, 1'b1);   // R11: local selector while busy, must be dropped
      end
      wait_outcome(d, f, o);
      chk("R7", "done", 32'({d, f, o}), 32'b100);
      chk("R7", "ctx_we at done", 32'(ctx_we), 1);
      for (int k = 0; k < NSLOT; k++) chk("R7", $sformatf("ctx_out slot %0d", k),
                                           ctx_out[k*32 +: 32], slot[k]);
      chk("R8", "task_base during done", task_base, old);
      @(negedge clk);
      chk("R8", "task_base after done", task_base, nbase);
      chk("R8", "ctx_we cycles", 32'(we_count - we0), 1);
      chk("R8", "stray task_base moves", 32'(tr_bad), 0);
      chk("R10", "held requests", 32'(hold_bad - hb0), 0);
      chk("R6", "access count", 32'(log_n), 32'(2 + 2*NSLOT));
      chk("R2", "desc word0 addr", log_addr[0], GDT + 32'(idx*8));
      chk("R2", "desc word1 addr", log_addr[1], GDT + 32'(idx*8 + 4));
      for (int k = 0; k < NSLOT; k++) begin
         chk("R6", $sformatf("store %0d", k), {log_we[2+k], log_addr[2+k]},
             {1'b1, old + 32'(4*k)});
         chk("R7", $sformatf("load %0d", k), {log_we[2+NSLOT+k], log_addr[2+NSLOT+k]},
             {1'b0, nbase + 32'(4*k)});
         chk("R6", $sformatf("saved slot %0d", k), mem[(old >> 2) + k],
             {16'(seed) ^ 16'hC0DE, 16'(k)});
      end
      chk("R6", "EIP at offset 0x20", mem[(old + 32'h20) >> 2], {16'(seed) ^ 16'hC0DE, 16'd8});
      chk("R9", "idle after done", 32'({busy, done, fault, other_xfer}), 0);
   endtask

   task automatic t_reject(input string req, input int idx, input bit ti, input bit exp_fault,
                           input int exp_log);
      logic [31:0] old;
      logic d, f, o;
      int we0;
      old = task_base; log_n = 0; we0 = we_count; wait_n = 1;
      pulse_start(idx, ti);
      wait_outcome(d, f, o);
      chk(req, "outcome", 32'({d, f, o}), exp_fault ? 32'b010 : 32'b001);
      chk(req, "accesses", 32'(log_n), 32'(exp_log));
      @(negedge clk);
      chk(req, "task_base", task_base, old);
      chk(req, "ctx_we cycles", 32'(we_count - we0), 0);
      chk(req, "idle", 32'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog got %h exp %h", 32'(0), 32'(1));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      set_desc(2, 32'h400, 4'h9);
      set_desc(3, 32'h600, 4'h9);
      set_desc(4, 32'h700, 4'h2);
      set_desc(5, 32'h700, 4'hB);
      set_desc(7, 32'h800, 4'h9);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_switch(2, 32'h400, 0, 1'b0);
      t_switch(3, 32'h600, 3, 1'b0);            // saves into area made current before
      t_reject("R3", 2, 1'b1, 1'b1, 0);         // local table
      t_reject("R4", 8, 1'b0, 1'b1, 0);         // last byte 0x47 past limit 0x3F
      t_reject("R5", 4, 1'b0, 1'b0, 2);         // plain segment type
      t_reject("R2", 5, 1'b0, 1'b0, 2);         // busy task type not accepted by default
      t_switch(7, 32'h800, 1, 1'b0);            // R4 boundary: last byte equals limit
      t_switch(2, 32'h400, 2, 1'b1);            // R11 start while busy
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule